// File: doc/BRIEF.md
# Externally Triggered ADC Scan Sequencer

This block steps an eight-input analog-to-digital converter through a programmed range of inputs. A scan always begins at input 0 and climbs one input at a time up to a last input chosen in a mode register. Each scan is launched by a rising edge on an external trigger pin, and only while the enable bit of the mode register is set. The converter is reached through a simple handshake: a one-cycle start strobe with a channel number goes out, and a done strobe with a 10-bit result comes back.

The first group of inputs (0 to 3) is converted back to back on one trigger. When the programmed range runs past that group, the sequencer changes to a per-trigger mode, and each further input waits for its own trigger edge. Each result lands in the result register of its own input. When the last programmed input is done, a single-cycle interrupt pulse is raised and the block goes idle until the next trigger. Clearing the enable bit aborts a scan at any point.

Software reaches the block through a flat register port: address 0 is the mode register (bit 7 enable, bits 2:0 last input, the other bits stored and read back), and addresses 8 to 15 read the result registers of inputs 0 to 7.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the mode register and every result register read 0, and the start strobe and interrupt are low.
- R2: A conversion of input n writes its 10-bit result into the result register of input n, read at address 8+n; a result register changes only on a done strobe.
- R3: Each scan issues starts for inputs 0, 1, 2, ... in ascending order, ending at the last input held in mode bits 2:0.
- R4: A scan begins only on a rising trigger edge while mode bit 7 (enable) is 1; a trigger with the enable bit at 0 issues no start.
- R5: When the last input is 3 or below, the interrupt fires after the last programmed conversion and no further start is issued.
- R6: Inputs 0 to 3 are converted on one trigger; each input from 4 upward is issued only after its own rising trigger edge.
- R7: A trigger edge that arrives while inputs 0 to 3 are being converted has no effect.
- R8: The interrupt is a one-cycle pulse raised exactly once per completed scan.
- R9: Writing the enable bit to 0 aborts a scan in progress: no further start, no interrupt, and result registers of unconverted inputs keep their values.
- R10: After a scan completes, a new trigger edge with the enable bit still 1 runs the whole scan again from input 0.
- R11: The mode register reads back at address 0 the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address (only 0 is writable) |
| reg_wdata | input | 8 | Write data for the mode register |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 10 | Read data, combinational from reg_raddr |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_ch | output | 3 | Input number for the current conversion |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 10 | Converter result, valid with conv_done |
| irq | output | 1 | End-of-scan interrupt pulse |

## Verification
The bench builds the block with its default parameters: eight inputs, a burst group of four and 10-bit results, with a converter model that answers five cycles after each start. With a group of four and eight inputs, last-input settings both inside and beyond the burst group are reachable, so the change into per-trigger mode, the wait for each later trigger and a mid-scan abort can all be driven. Result values are derived from a per-scan seed and the input number, so a write into the wrong register or a stale value left after an abort shows up on readback.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_TRIG  = 2'd3
  } scan_state_t;
endpackage

// File: rtl/adc_scan_rst_sync.sv
module adc_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/adc_scan_trig_sync.sv
module adc_scan_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= trig_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign trig_rise = sync_q & ~prev_q;
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int GROUP  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CH_W-1:0] last_ch,
  input  logic            trig_rise,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            res_we,
  output logic [CH_W-1:0] res_ch,
  output logic            irq
);
  localparam logic [CH_W:0] GROUP_LIM = (CH_W+1)'(GROUP);

  scan_state_t     state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [CH_W-1:0] last_q, last_d;
  logic            ch_ce;
  logic            irq_d;
  logic [CH_W:0]   ch_nxt;

  assign ch_nxt = {1'b0, ch_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    last_d  = last_q;
    ch_ce   = 1'b0;
    irq_d   = 1'b0;
    res_we  = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (trig_rise) begin
            state_d = ST_ISSUE;
            ch_d    = '0;
            last_d  = last_ch;
            ch_ce   = 1'b1;
          end
        end
        ST_ISSUE: state_d = ST_WAIT;
        ST_WAIT: begin
          if (conv_done) begin
            res_we = 1'b1;
            if (ch_q == last_q) begin
              irq_d   = 1'b1;
              state_d = ST_IDLE;
            end else begin
              ch_d    = ch_nxt[CH_W-1:0];
              ch_ce   = 1'b1;
              state_d = (ch_nxt < GROUP_LIM) ? ST_ISSUE : ST_TRIG;
            end
          end
        end
        ST_TRIG: begin
          if (trig_rise) state_d = ST_ISSUE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      last_q  <= '0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= irq_d;
      if (ch_ce) begin
        ch_q   <= ch_d;
        last_q <= last_d;
      end
    end
  end

  assign conv_start = (state_q == ST_ISSUE);
  assign conv_ch    = ch_q;
  assign res_ch     = ch_q;
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [CH_W-1:0]              wr_ch,
  input  logic [RES_W-1:0]             wr_data,
  output logic [NUM_CH-1:0][RES_W-1:0] res
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic slot_ce;
    assign slot_ce = we && (wr_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       res[g] <= '0;
      else if (slot_ce) res[g] <= wr_data;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH  = 8,
  parameter int GROUP   = 4,
  parameter int RES_W   = 10,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int RD_W   = (RES_W > 8) ? RES_W : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [RD_W-1:0]   reg_rdata,
  input  logic              trig_in,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);
  logic                         rst_ns;
  logic [7:0]                   mode_q;
  logic                         mode_ce;
  logic                         mode_en;
  logic [CH_W-1:0]              mode_last;
  logic                         trig_rise;
  logic                         res_we;
  logic [CH_W-1:0]              res_ch;
  logic [NUM_CH-1:0][RES_W-1:0] res;

  adc_scan_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign mode_ce = reg_wr && (reg_waddr == '0);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      mode_q <= '0;
    else if (mode_ce) mode_q <= reg_wdata;
  end

  assign mode_en   = mode_q[7];
  assign mode_last = mode_q[CH_W-1:0];

  adc_scan_trig_sync u_trig (
    .clk(clk), .rst_n(rst_ns), .trig_async(trig_in), .trig_rise(trig_rise)
  );

  adc_scan_fsm #(.NUM_CH(NUM_CH), .GROUP(GROUP)) u_fsm (
    .clk(clk), .rst_n(rst_ns), .en(mode_en), .last_ch(mode_last),
    .trig_rise(trig_rise), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .res_we(res_we), .res_ch(res_ch), .irq(irq)
  );

  adc_scan_results #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_ns), .we(res_we), .wr_ch(res_ch),
    .wr_data(conv_result), .res(res)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr[ADDR_W-1]) reg_rdata[RES_W-1:0] = res[reg_raddr[CH_W-1:0]];
    else if (reg_raddr == '0) reg_rdata[7:0] = mode_q;
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_ch,
  input logic            conv_done,
  input logic            irq
);
  // R8: interrupt lasts one cycle
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: interrupt follows a converter done strobe
  a_r5_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(conv_done));

  // R4: a start needs the enable bit in the cycle that issued it
  a_r4_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(enable));

  // R9: once enable reads 0 no start follows
  a_r9_abort_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !conv_start);

  // R3: each start is a single-cycle request with a stable channel
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (!conv_start && $stable(conv_ch)));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(mode_en), .conv_start(conv_start),
  .conv_ch(conv_ch), .conv_done(conv_done), .irq(irq)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
  localparam int LAT = 5;

  logic       clk, rst_n;
  logic       reg_wr;
  logic [3:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata;
  logic [9:0] reg_rdata;
  logic       trig_in;
  logic       conv_start;
  logic [2:0] conv_ch;
  logic       conv_done;
  logic [9:0] conv_result;
  logic       irq;

  adc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .trig_in(trig_in), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int n_start = 0, n_irq = 0, n_done = 0;
  int seed = 0;
  logic [2:0] log_ch [64];
  bit finished = 0;

  function automatic logic [9:0] expv(int s, int ch);
    return 10'((s * 37 + ch * 5 + 1) & 10'h3FF);
  endfunction

  // converter model
  int cnt_q = 0;
  logic [2:0] ch_q;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      cnt_q <= LAT;
      ch_q  <= conv_ch;
    end else if (cnt_q > 0) begin
      cnt_q <= cnt_q - 1;
      if (cnt_q == 1) begin
        conv_done   <= 1'b1;
        conv_result <= expv(seed, int'(ch_q));
      end
    end
  end

  // monitor
  always @(posedge clk) begin
    if (conv_start) begin
      if (n_start < 64) log_ch[n_start] = conv_ch;
      n_start++;
    end
    if (irq) n_irq++;
    if (conv_done) n_done++;
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic en, int last);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 4'd0; reg_wdata = {en, 4'b0, 3'(last)};
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int addr, output int val);
    @(negedge clk);
    reg_raddr = 4'(addr);
    #0.5;
    val = int'(reg_rdata);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_irq(int target);
    for (int i = 0; i < 400 && n_irq < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 irq", int'(irq), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    rd(0, v); chk("R1 mode", v, 0);
    for (int c = 0; c < 8; c++) begin
      rd(8 + c, v); chk("R1 result", v, 0);
    end
  endtask

  task automatic t_disabled();
    int v;
    pulse_trig();
    repeat (20) @(negedge clk);
    chk("R4 no start when disabled", n_start, 0);
    rd(8, v); chk("R4 result0 untouched", v, 0);
  endtask

  task automatic t_short();
    int v, s0, i0;
    seed = 1; s0 = n_start; i0 = n_irq;
    wr_mode(1'b1, 2);
    rd(0, v); chk("R11 mode readback", v, 8'h82);
    pulse_trig();
    wait_irq(i0 + 1);
    repeat (20) @(negedge clk);
    chk("R5 start count", n_start - s0, 3);
    chk("R8 irq once", n_irq - i0, 1);
    for (int c = 0; c < 3; c++) begin
      chk("R3 order", int'(log_ch[s0 + c]), c);
      rd(8 + c, v); chk("R2 result", v, int'(expv(1, c)));
    end
    rd(11, v); chk("R2 result3 not written", v, 0);
  endtask

  task automatic t_burst_ignore();
    int v, s0, i0;
    seed = 2; s0 = n_start; i0 = n_irq;
    wr_mode(1'b1, 3);
    pulse_trig();
    for (int i = 0; i < 50 && n_start == s0; i++) @(negedge clk);
    pulse_trig();
    wait_irq(i0 + 1);
    repeat (30) @(negedge clk);
    chk("R7 starts with mid-burst trigger", n_start - s0, 4);
    chk("R7 irq once", n_irq - i0, 1);
    rd(11, v); chk("R2 result3", v, int'(expv(2, 3)));
  endtask

  task automatic t_trig_mode();
    int v, s0, i0;
    seed = 3; s0 = n_start; i0 = n_irq;
    wr_mode(1'b1, 6);
    pulse_trig();
    repeat (60) @(negedge clk);
    chk("R6 burst stops at group end", n_start - s0, 4);
    chk("R6 no irq yet", n_irq - i0, 0);
    for (int c = 4; c <= 6; c++) begin
      pulse_trig();
      repeat (15) @(negedge clk);
      chk("R6 one start per trigger", n_start - s0, c + 1);
      chk("R6 channel", int'(log_ch[s0 + c]), c);
    end
    wait_irq(i0 + 1);
    chk("R8 irq once in trigger mode", n_irq - i0, 1);
    for (int c = 0; c <= 6; c++) begin
      rd(8 + c, v); chk("R2 result", v, int'(expv(3, c)));
    end
    rd(15, v); chk("R2 result7 not written", v, 0);
  endtask

  task automatic t_abort();
    int v, s0, i0, d0;
    seed = 5; s0 = n_start; i0 = n_irq; d0 = n_done;
    wr_mode(1'b1, 7);
    pulse_trig();
    for (int i = 0; i < 100 && n_done < d0 + 2; i++) @(negedge clk);
    wr_mode(1'b0, 7);
    repeat (40) @(negedge clk);
    chk("R9 no irq after abort", n_irq - i0, 0);
    chk("R9 starts before abort", n_start - s0, 3);
    rd(8, v); chk("R9 result0 new", v, int'(expv(5, 0)));
    rd(9, v); chk("R9 result1 new", v, int'(expv(5, 1)));
    rd(10, v); chk("R9 result2 kept", v, int'(expv(3, 2)));
    rd(11, v); chk("R9 result3 kept", v, int'(expv(3, 3)));
    rd(15, v); chk("R9 result7 kept", v, 0);
    s0 = n_start;
    pulse_trig();
    repeat (20) @(negedge clk);
    chk("R4 trigger after abort ignored", n_start - s0, 0);
  endtask

  task automatic t_restart();
    int v, s0, i0;
    seed = 6; i0 = n_irq;
    wr_mode(1'b1, 1);
    pulse_trig();
    wait_irq(i0 + 1);
    repeat (10) @(negedge clk);
    seed = 7; s0 = n_start;
    pulse_trig();
    wait_irq(i0 + 2);
    repeat (10) @(negedge clk);
    chk("R10 irq per scan", n_irq - i0, 2);
    chk("R10 restart count", n_start - s0, 2);
    chk("R10 restart from 0", int'(log_ch[s0]), 0);
    rd(8, v); chk("R10 result0", v, int'(expv(7, 0)));
    rd(9, v); chk("R10 result1", v, int'(expv(7, 1)));
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0;
    reg_raddr = '0; trig_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_short();
    t_burst_ignore();
    t_trig_mode();
    t_abort();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule